// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block lets software on one processor raise an interrupt on other processors. It is a pair of 32-bit command registers on a simple register port. The upper word names a target processor. A write to the lower word carries the vector, the delivery mode, the trigger and level flags and a destination shorthand, and that write launches one message on a valid/ready output.

While the message waits for the downstream consumer, a status bit in the lower word reads as busy. Software polls that bit until it reads idle before it sends the next command. The block resolves the destination shorthand into a concrete target and a "this processor included" flag, comparing against a local processor ID input. It also captures all message fields at launch, so later register writes cannot disturb a message in flight.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, both command words read 0, `msg_valid` is 0 and the status bit (low word bit 12) reads 0.
- R2: A write to the high word (byte offset 0x310) is stored in full and reads back unchanged; its bits 31:24 are the target processor ID.
- R3: A write to the low word (byte offset 0x300) while idle raises `msg_valid` in the next cycle. It carries vector = bits 7:0, mode = bits 10:8 (0 fixed, 5 INIT, 6 startup, whose vector is the start page number), level = bit 15 and assert = bit 14.
- R4: Low word bit 12 reads 1 from the launch until the cycle after the `msg_valid`/`msg_ready` handshake, and 0 from then on.
- R5: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and every message field hold steady.
- R6: A write to the low word while busy is dropped: it sends no second message and leaves the low word readback unchanged.
- R7: Shorthand bits 19:18 = 2'b10 sends to every processor including the sender: `msg_dest` = 8'hFF and `msg_incl_self` = 1, whatever the high word holds.
- R8: Shorthand 2'b00 targets the high word's ID, and `msg_incl_self` is 1 only when that ID equals `local_id`. 2'b01 targets `local_id` with `msg_incl_self` = 1. 2'b11 gives `msg_dest` = 8'hFF with `msg_incl_self` = 0.
- R9: A level-triggered INIT with assert clear is launched as a message like any other command.
- R10: Every low word bit except bit 12 reads back as last written; the written value of bit 12 is not stored.
- R11: A write to the high word while busy updates the readback but not the `msg_dest` of the message in flight.
- R12: Other offsets read 0, and writes to them change nothing and send nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| local_id | input | 8 | ID of the processor that owns this unit |
| msg_valid | output | 1 | Message offered downstream |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Vector, or start page for startup |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | 1 level-triggered, 0 edge |
| msg_assert | output | 1 | 1 assert, 0 deassert |
| msg_shorthand | output | 2 | Destination shorthand as written |
| msg_dest | output | 8 | Resolved target ID (8'hFF for all) |
| msg_incl_self | output | 1 | Message also reaches the sender |

## Verification
The bench holds `msg_ready` low and rewrites both command words while a message waits. A design that queued the second command would deliver an extra message, and one that read fields live from the registers would deliver the wrong target. The bench then keeps `msg_ready` high for several cycles after the handshake, which exposes a unit that sends the same command twice or clears its status a cycle late. The bench also runs the broadcast shorthand against a conflicting high word, sends an INIT deassert that a design might wrongly filter out, and writes a 1 to the status bit, which a design might store in the readback.

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit #(
  parameter int          ADDR_W = 12,
  parameter logic [11:0] LO_OFS = 12'h300,
  parameter logic [11:0] HI_OFS = 12'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [7:0]        local_id,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_level,
  output logic              msg_assert,
  output logic [1:0]        msg_shorthand,
  output logic [7:0]        msg_dest,
  output logic              msg_incl_self
);
  localparam int          STAT_BIT = 12;
  localparam logic [31:0] STAT_MSK = 32'h1 << STAT_BIT;
  localparam logic [7:0]  ALL_IDS  = 8'hFF;

  logic [31:0] lo_q, hi_q;
  logic        busy;
  logic        sel_lo, sel_hi, launch;
  logic [1:0]  sh_in;
  logic [7:0]  tgt_in, dst_in;
  logic        self_in;

  assign sel_lo = reg_addr == ADDR_W'(LO_OFS);
  assign sel_hi = reg_addr == ADDR_W'(HI_OFS);
  assign launch = reg_wr && sel_lo && !busy;

  assign sh_in  = reg_wdata[19:18];
  assign tgt_in = hi_q[31:24];

  always_comb begin
    unique case (sh_in)
      2'b00:   begin dst_in = tgt_in;   self_in = (tgt_in == local_id); end
      2'b01:   begin dst_in = local_id; self_in = 1'b1; end
      2'b10:   begin dst_in = ALL_IDS;  self_in = 1'b1; end
      default: begin dst_in = ALL_IDS;  self_in = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      busy <= 1'b0;
    end else begin
      if (reg_wr && sel_hi) hi_q <= reg_wdata;
      if (launch)           lo_q <= reg_wdata & ~STAT_MSK;
      if (launch)                      busy <= 1'b1;
      else if (busy && msg_ready)      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_vector    <= '0;
      msg_mode      <= '0;
      msg_level     <= 1'b0;
      msg_assert    <= 1'b0;
      msg_shorthand <= '0;
      msg_dest      <= '0;
      msg_incl_self <= 1'b0;
    end else if (launch) begin
      msg_vector    <= reg_wdata[7:0];
      msg_mode      <= reg_wdata[10:8];
      msg_level     <= reg_wdata[15];
      msg_assert    <= reg_wdata[14];
      msg_shorthand <= sh_in;
      msg_dest      <= dst_in;
      msg_incl_self <= self_in;
    end
  end

  assign msg_valid = busy;
  assign reg_rdata = sel_lo ? (lo_q | (busy ? STAT_MSK : 32'h0)) :
                     sel_hi ? hi_q : 32'h0;
endmodule

module ipi_cmd_unit_chk #(
  parameter int          ADDR_W = 12,
  parameter logic [11:0] LO_OFS = 12'h300
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_mode,
  input logic              msg_level,
  input logic              msg_assert,
  input logic [1:0]        msg_shorthand,
  input logic [7:0]        msg_dest,
  input logic              msg_incl_self
);
  logic lo_hit;
  assign lo_hit = reg_addr == ADDR_W'(LO_OFS);

  AST_LAUNCH_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && lo_hit && !msg_valid) |=> msg_valid);  // R3
  AST_STATUS_TRACKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |-> (reg_rdata[12] == msg_valid));  // R4
  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);  // R6
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);  // R5
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> $stable({msg_vector, msg_mode, msg_level, msg_assert,
                                           msg_shorthand, msg_dest, msg_incl_self}));  // R11
  AST_BCAST_ALL_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_shorthand == 2'b10) |-> (msg_dest == 8'hFF && msg_incl_self));  // R7
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.ADDR_W(ADDR_W), .LO_OFS(LO_OFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
  .msg_mode(msg_mode), .msg_level(msg_level), .msg_assert(msg_assert),
  .msg_shorthand(msg_shorthand), .msg_dest(msg_dest), .msg_incl_self(msg_incl_self)
);

// File: tb/ipi_cmd_unit_tb_top.sv
module ipi_cmd_unit_tb_top;
  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  local_id = 8'h07;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_mode;
  logic        msg_level, msg_assert, msg_incl_self;
  logic [1:0]  msg_shorthand;

  int checks = 0;
  int errors = 0;
  int received = 0;
  int expected_n = 0;
  logic [23:0] exp_q[$];
  logic [31:0] hi_model = '0;

  always #4 clk = ~clk;

  ipi_cmd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .local_id(local_id), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_level(msg_level),
    .msg_assert(msg_assert), .msg_shorthand(msg_shorthand), .msg_dest(msg_dest),
    .msg_incl_self(msg_incl_self)
  );

  function automatic logic [23:0] pack_exp(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [7:0] me);
    logic [7:0] d;
    logic       s;
    case (lo[19:18])
      2'b00:   begin d = hi[31:24]; s = (hi[31:24] == me); end
      2'b01:   begin d = me;        s = 1'b1; end
      2'b10:   begin d = 8'hFF;     s = 1'b1; end
      default: begin d = 8'hFF;     s = 1'b0; end
    endcase
    return {lo[7:0], lo[10:8], lo[15], lo[14], lo[19:18], d, s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input logic [31:0] lo);
    exp_q.push_back(pack_exp(lo, hi_model, local_id));
    expected_n++;
    wr(LO, lo);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : monitor
    logic [23:0] got, want;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && msg_valid && msg_ready) begin
        got = {msg_vector, msg_mode, msg_level, msg_assert, msg_shorthand, msg_dest, msg_incl_self};
        received++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 actual=%h expected=no message", got);
        end else begin
          want = exp_q.pop_front();
          check("R3/R7/R8/R9/R11 message", {8'h0, got}, {8'h0, want});
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    rd(LO, v); check("R1 low word", v, 32'h0);
    rd(HI, v); check("R1 high word", v, 32'h0);
    check("R1 valid", {31'h0, msg_valid}, 32'h0);

    hi_model = 32'h0500_00A5; wr(HI, hi_model);
    rd(HI, v); check("R2 high readback", v, 32'h0500_00A5);

    send(32'h0000_C531);
    check("R3 valid raised", {31'h0, msg_valid}, 32'h1);
    rd(LO, v); check("R4 busy readback", v, 32'h0000_D531);
    wr(LO, 32'h0000_0020);
    rd(LO, v); check("R6 busy write dropped", v, 32'h0000_D531);
    hi_model = 32'h0700_0000; wr(HI, hi_model);
    rd(HI, v); check("R11 high readback while busy", v, 32'h0700_0000);
    idle(3);
    check("R5 vector held", {24'h0, msg_vector}, 32'h31);
    check("R11 dest held", {24'h0, msg_dest}, 32'h05);
    @(negedge clk) msg_ready = 1'b1;
    idle(1);
    rd(LO, v); check("R4 idle after ack", v, 32'h0000_C531);
    idle(4);

    send(32'h0008_8500);
    idle(3);
    send(32'h0000_0041);
    idle(3);
    hi_model = 32'h0300_0000; wr(HI, hi_model);
    send(32'h0000_0042);
    idle(3);
    send(32'h0000_069A);
    idle(3);
    send(32'h000C_0043);
    idle(3);
    send(32'h0004_0044);
    idle(3);

    @(negedge clk) msg_ready = 1'b0;
    send(32'h0000_1046);
    rd(LO, v); check("R10 status shows busy", v, 32'h0000_1046);
    @(negedge clk) msg_ready = 1'b1;
    idle(3);
    rd(LO, v); check("R10 written bit 12 not kept", v, 32'h0000_0046);

    wr(12'h320, 32'hFFFF_FFFF);
    rd(12'h320, v); check("R12 other offset", v, 32'h0);
    rd(HI, v); check("R12 high untouched", v, 32'h0300_0000);
    idle(4);
    check("R12 no stray message", received, expected_n);
    check("R6 queue drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule